// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Writer

This block places each packet arriving on a byte stream into host memory buffers described by a ring of two-word receive descriptors that software prepares. Word 0 of a descriptor carries control flags and a buffer length; word 1 carries the buffer's byte address. The block reads descriptors and writes payload and status through a single 32-bit memory master port that has one transaction in flight at a time.

A packet may span several chained buffers. The status of every buffer after the first is written back as soon as that buffer is closed. The status of the first buffer is written last, so software sees the packet only after every other part is in place. An interrupt pulse follows that final write. Packets that cannot be placed are consumed from the stream and discarded, so the stream never backs up.

Software loads the ring start and the current descriptor pointer through a small register port. The CRC size added to the final length is selected by an input pin.

Top module: `rx_ring_dma`

## Requirements
- R1: A descriptor is two 32-bit words at an 8-byte-aligned address. Word 0 has ownership in bit 31, wrap in bit 30, continue in bit 27 and a 13-bit length in bits 12:0. Word 1, at +4, is the buffer byte address. For the current descriptor, word 0 is read before word 1.
- R2: When a packet starts while the ring start register is zero, the whole packet is accepted and discarded. No memory transaction is made and no interrupt is raised.
- R3: When word 0 of the current descriptor has bit 31 clear, the packet is accepted and discarded. No memory write is made, the current pointer is unchanged and no interrupt is raised.
- R4: Byte k of a buffer goes into lane k mod 4 (bits 8*lane+7:8*lane) of the word at buffer address + 4*(k div 4). Each write enables only the lanes it carries. A buffer receives the smaller of its length field and the bytes still to be placed.
- R5: The descriptor after the current one is the ring start when the current descriptor has wrap set, and current + 8 otherwise. Each descriptor that is consumed advances the current pointer register to that address.
- R6: When a packet ends in a buffer, that descriptor's word 0 is written as the bytes copied plus the CRC size. The CRC size is 2 when crc_wide_i is 0 and 4 when it is 1. Bits 31, 30 and 27 of this status are clear.
- R7: When bytes remain after a buffer fills, word 0 of the next descriptor is read. If bit 31 of that word is set, the filled buffer's status is bit 27 set OR the bytes copied, and placement continues in the next buffer.
- R8: When bytes remain and the next descriptor has bit 31 clear, the filled buffer's status is the bytes copied alone. The rest of the packet is discarded, and the current pointer is left at the unowned descriptor.
- R9: Statuses of descriptors after the first are written as each is closed. The first descriptor's status is always the last memory write of the packet. irq_o is high for exactly one cycle, the cycle after that write completes.
- R10: A packet longer than 8192 bytes is cut to 8192 bytes. The final status reflects only the bytes placed, and the excess input bytes are accepted and discarded.
- R11: The register port reads and writes the ring start at offset 0x04 and the current pointer at offset 0x08. Reads of other offsets return zero. Both registers reset to zero, and a software write to the current pointer takes priority over an advance in the same cycle.
- R12: mem_req_o holds its address, direction, data and enables stable until mem_ready_i completes the transaction, and only one transaction is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| crc_wide_i | input | 1 | CRC size select: 0 adds 2, 1 adds 4 |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | Marks the last byte of a packet |
| s_ready_o | output | 1 | Stream byte accepted when high with s_valid_i |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_be_o | output | 4 | Write byte enables |
| mem_rdata_i | input | 32 | Memory read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Completes the current transaction |
| irq_o | output | 1 | Packet placed, one-cycle pulse |

## Verification
The properties rely on several conditions. Buffer addresses are word aligned. crc_wide_i and the register contents stay unchanged while a packet is being placed. The memory answers every request eventually, and its read data is valid in the cycle mem_ready_i is high. The stimulus meets these conditions. It points word 1 of every descriptor at a 4-byte-aligned buffer and writes the registers only between packets. The responding memory model gives each transaction a 1- to 3-cycle latency, with the delay rotating so that holds of different lengths are exercised. It also never offers a ring made only of zero-length owned descriptors, which would keep the block chaining forever.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned LEN_W    = 13;
  localparam int unsigned OWN_B    = 31;
  localparam int unsigned WRAP_B   = 30;
  localparam int unsigned CONT_B   = 27;
  localparam int unsigned DESC_SZ  = 8;
  localparam int unsigned LANES    = DW / 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_W0,
    ST_RD_W1,
    ST_FILL,
    ST_WR_DATA,
    ST_RD_NEXT,
    ST_WR_STAT,
    ST_WR_FIRST,
    ST_DRAIN
  } rx_state_e;
endpackage

// File: rtl/rx_ring_regs.sv
module rx_ring_regs
  import rx_ring_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [3:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          adv_i,
  input  logic [DW-1:0] adv_addr_i,
  output logic [DW-1:0] start_o,
  output logic [DW-1:0] cur_o
);
  localparam logic [3:0] OFF_START = 4'h4;
  localparam logic [3:0] OFF_CUR   = 4'h8;

  logic [DW-1:0] start_q, cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      cur_q   <= '0;
    end else begin
      if (we_i && addr_i == OFF_START) start_q <= wdata_i;
      // software write wins over a hardware advance
      if (we_i && addr_i == OFF_CUR) cur_q <= wdata_i;
      else if (adv_i)                cur_q <= adv_addr_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_START: rdata_o = start_q;
      OFF_CUR:   rdata_o = cur_q;
      default:   rdata_o = '0;
    endcase
  end

  assign start_o = start_q;
  assign cur_o   = cur_q;
endmodule

// File: rtl/rx_byte_packer.sv
module rx_byte_packer
  import rx_ring_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     push_i,
  input  logic [$clog2(LANES)-1:0] lane_i,
  input  logic [7:0]               byte_i,
  output logic [DW-1:0]            word_o,
  output logic [LANES-1:0]         be_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_o[8*g +: 8] <= '0;
        be_o[g]          <= 1'b0;
      end else if (clr_i) begin
        be_o[g] <= 1'b0;
      end else if (push_i && lane_i == g) begin
        word_o[8*g +: 8] <= byte_i;
        be_o[g]          <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
#(
  parameter int unsigned MAX_PKT_BYTES = 8192
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [DW-1:0]            ring_start_i,
  input  logic [DW-1:0]            ring_cur_i,
  input  logic                     crc_wide_i,
  input  logic                     s_valid_i,
  input  logic                     s_last_i,
  output logic                     s_ready_o,
  output logic                     push_o,
  output logic [$clog2(LANES)-1:0] lane_o,
  output logic                     pk_clr_o,
  input  logic [DW-1:0]            pk_word_i,
  input  logic [LANES-1:0]         pk_be_i,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [DW-1:0]            mem_addr_o,
  output logic [DW-1:0]            mem_wdata_o,
  output logic [LANES-1:0]         mem_be_o,
  input  logic [DW-1:0]            mem_rdata_i,
  input  logic                     mem_ready_i,
  output logic                     adv_o,
  output logic [DW-1:0]            adv_addr_o,
  output logic                     irq_o,
  output rx_state_e                state_o
);
  localparam int unsigned TOT_W = $clog2(MAX_PKT_BYTES + 1);
  localparam logic [TOT_W-1:0] TOT_MAX = TOT_W'(MAX_PKT_BYTES);
  localparam int unsigned LW = $clog2(LANES);

  rx_state_e        state_q;
  logic [DW-1:0]    desc_q, first_q, baddr_q, waddr_q, stat_q, fstat_q;
  logic             is_first_q, wrap_q, last_q, fin_q, irq_q;
  logic             nwrap_q;
  logic [LEN_W-1:0] blen_q, nlen_q, cnt_q;
  logic [TOT_W-1:0] tot_q;

  logic [DW-1:0]    next_addr, crc_add, end_stat, chain_stat;
  logic [LEN_W-1:0] cnt_n;
  logic [TOT_W-1:0] tot_n;
  logic             ended, flush, nxt_own;

  assign next_addr  = wrap_q ? ring_start_i : desc_q + DW'(DESC_SZ);
  assign crc_add    = crc_wide_i ? DW'(4) : DW'(2);
  assign end_stat   = DW'(cnt_q) + crc_add;
  assign nxt_own    = mem_rdata_i[OWN_B];
  assign chain_stat = (nxt_own ? (DW'(1) << CONT_B) : '0) | DW'(cnt_q);
  assign ended      = last_q || (tot_q == TOT_MAX);
  assign cnt_n      = cnt_q + 1'b1;
  assign tot_n      = tot_q + 1'b1;
  assign lane_o     = cnt_q[LW-1:0];
  assign push_o     = (state_q == ST_FILL) && s_valid_i;
  assign flush      = (lane_o == LW'(LANES - 1)) || s_last_i ||
                      (tot_n == TOT_MAX) || (cnt_n == blen_q);
  assign s_ready_o  = (state_q == ST_FILL) || (state_q == ST_DRAIN);
  assign pk_clr_o   = (state_q == ST_WR_DATA) && mem_ready_i;
  assign irq_o      = irq_q;
  assign state_o    = state_q;
  assign adv_addr_o = next_addr;
  assign adv_o      = mem_ready_i &&
                      ((state_q == ST_WR_STAT) ||
                       (state_q == ST_RD_NEXT && is_first_q) ||
                       (state_q == ST_WR_DATA && ended && is_first_q));

  always_comb begin
    mem_req_o   = 1'b1;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_q;
    mem_wdata_o = '0;
    mem_be_o    = '1;
    unique case (state_q)
      ST_RD_W0:    mem_addr_o = desc_q;
      ST_RD_W1:    mem_addr_o = desc_q + DW'(4);
      ST_RD_NEXT:  mem_addr_o = next_addr;
      ST_WR_DATA: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = waddr_q;
        mem_wdata_o = pk_word_i;
        mem_be_o    = pk_be_i;
      end
      ST_WR_STAT: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = stat_q;
      end
      ST_WR_FIRST: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = first_q;
        mem_wdata_o = fstat_q;
      end
      default:     mem_req_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      desc_q     <= '0;
      first_q    <= '0;
      baddr_q    <= '0;
      waddr_q    <= '0;
      stat_q     <= '0;
      fstat_q    <= '0;
      is_first_q <= 1'b0;
      wrap_q     <= 1'b0;
      last_q     <= 1'b0;
      fin_q      <= 1'b0;
      irq_q      <= 1'b0;
      nwrap_q    <= 1'b0;
      blen_q     <= '0;
      nlen_q     <= '0;
      cnt_q      <= '0;
      tot_q      <= '0;
    end else begin
      irq_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (s_valid_i) begin
          if (ring_start_i == '0) begin
            state_q <= ST_DRAIN;
          end else begin
            desc_q     <= ring_cur_i;
            first_q    <= ring_cur_i;
            is_first_q <= 1'b1;
            tot_q      <= '0;
            last_q     <= 1'b0;
            fin_q      <= 1'b0;
            state_q    <= ST_RD_W0;
          end
        end
        ST_RD_W0: if (mem_ready_i) begin
          if (!mem_rdata_i[OWN_B]) begin
            state_q <= ST_DRAIN;
          end else begin
            wrap_q  <= mem_rdata_i[WRAP_B];
            blen_q  <= mem_rdata_i[LEN_W-1:0];
            state_q <= ST_RD_W1;
          end
        end
        ST_RD_W1: if (mem_ready_i) begin
          baddr_q <= mem_rdata_i;
          cnt_q   <= '0;
          state_q <= (blen_q == '0) ? ST_RD_NEXT : ST_FILL;
        end
        ST_FILL: if (s_valid_i) begin
          waddr_q <= baddr_q + {{(DW-LEN_W){1'b0}}, cnt_q[LEN_W-1:LW], {LW{1'b0}}};
          cnt_q   <= cnt_n;
          tot_q   <= tot_n;
          last_q  <= s_last_i;
          if (flush) state_q <= ST_WR_DATA;
        end
        ST_WR_DATA: if (mem_ready_i) begin
          if (ended) begin
            fin_q <= 1'b1;
            if (is_first_q) begin
              fstat_q <= end_stat;
              state_q <= ST_WR_FIRST;
            end else begin
              stat_q  <= end_stat;
              state_q <= ST_WR_STAT;
            end
          end else if (cnt_q == blen_q) begin
            state_q <= ST_RD_NEXT;
          end else begin
            state_q <= ST_FILL;
          end
        end
        ST_RD_NEXT: if (mem_ready_i) begin
          fin_q   <= !nxt_own;
          nwrap_q <= mem_rdata_i[WRAP_B];
          nlen_q  <= mem_rdata_i[LEN_W-1:0];
          if (is_first_q) begin
            fstat_q <= chain_stat;
            if (!nxt_own) begin
              state_q <= ST_WR_FIRST;
            end else begin
              desc_q     <= next_addr;
              wrap_q     <= mem_rdata_i[WRAP_B];
              blen_q     <= mem_rdata_i[LEN_W-1:0];
              is_first_q <= 1'b0;
              state_q    <= ST_RD_W1;
            end
          end else begin
            stat_q  <= chain_stat;
            state_q <= ST_WR_STAT;
          end
        end
        ST_WR_STAT: if (mem_ready_i) begin
          if (fin_q) begin
            state_q <= ST_WR_FIRST;
          end else begin
            desc_q  <= next_addr;
            wrap_q  <= nwrap_q;
            blen_q  <= nlen_q;
            state_q <= ST_RD_W1;
          end
        end
        ST_WR_FIRST: if (mem_ready_i) begin
          irq_q   <= 1'b1;
          state_q <= last_q ? ST_IDLE : ST_DRAIN;
        end
        ST_DRAIN: if (s_valid_i && s_last_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
  import rx_ring_pkg::*;
#(
  parameter int unsigned MAX_PKT_BYTES = 8192
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [3:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        crc_wide_i,
  input  logic        s_valid_i,
  input  logic [7:0]  s_data_i,
  input  logic        s_last_i,
  output logic        s_ready_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  output logic [3:0]  mem_be_o,
  input  logic [31:0] mem_rdata_i,
  input  logic        mem_ready_i,
  output logic        irq_o
);
  localparam int unsigned LW = $clog2(LANES);

  logic [DW-1:0]    ring_start, ring_cur, adv_addr, pk_word;
  logic             adv, push, pk_clr;
  logic [LW-1:0]    lane;
  logic [LANES-1:0] pk_be;
  rx_state_e        ctrl_state;

  rx_ring_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .adv_i      (adv),
    .adv_addr_i (adv_addr),
    .start_o    (ring_start),
    .cur_o      (ring_cur)
  );

  rx_byte_packer u_pack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pk_clr),
    .push_i (push),
    .lane_i (lane),
    .byte_i (s_data_i),
    .word_o (pk_word),
    .be_o   (pk_be)
  );

  rx_ring_ctrl #(.MAX_PKT_BYTES(MAX_PKT_BYTES)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ring_start_i (ring_start),
    .ring_cur_i   (ring_cur),
    .crc_wide_i   (crc_wide_i),
    .s_valid_i    (s_valid_i),
    .s_last_i     (s_last_i),
    .s_ready_o    (s_ready_o),
    .push_o       (push),
    .lane_o       (lane),
    .pk_clr_o     (pk_clr),
    .pk_word_i    (pk_word),
    .pk_be_i      (pk_be),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_be_o     (mem_be_o),
    .mem_rdata_i  (mem_rdata_i),
    .mem_ready_i  (mem_ready_i),
    .adv_o        (adv),
    .adv_addr_o   (adv_addr),
    .irq_o        (irq_o),
    .state_o      (ctrl_state)
  );
endmodule

// File: rtl/rx_ring_dma_chk.sv
module rx_ring_dma_chk
  import rx_ring_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [1:0]  stat_top_i,
  input logic [3:0]  mem_be_o,
  input logic        mem_ready_i,
  input logic        irq_o,
  input rx_state_e   ctrl_state
);
  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_be_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_be_o != 4'b0000));

  p_status_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && (ctrl_state == ST_WR_STAT || ctrl_state == ST_WR_FIRST))
      |-> (stat_top_i == 2'b00));

  p_irq_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_after_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(mem_req_o && mem_we_o && mem_ready_i));

  p_drain_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_state == ST_DRAIN) |-> !mem_req_o);
endmodule

bind rx_ring_dma rx_ring_dma_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .stat_top_i  (mem_wdata_o[31:30]),
  .mem_be_o    (mem_be_o),
  .mem_ready_i (mem_ready_i),
  .irq_o       (irq_o),
  .ctrl_state  (ctrl_state)
);

// File: tb/sim_rx_ring_dma.sv
module sim_rx_ring_dma;
  localparam logic [31:0] DA = 32'h100, DB = 32'h108;
  localparam logic [31:0] BA = 32'h1000, BB = 32'h3800;
  // lenA, wordB, pkt_len, crc_wide, expA, expB, expCur
  localparam logic [31:0] VEC [0:5][0:6] = '{
    '{32'd64, 32'hC0000040, 32'd10, 32'd0, 32'h0000000C, 32'hC0000040, 32'h108},
    '{32'd8,  32'hC0000040, 32'd20, 32'd1, 32'h08000008, 32'h00000010, 32'h100},
    '{32'd8,  32'h40000040, 32'd20, 32'd0, 32'h00000008, 32'h40000040, 32'h108},
    '{32'd7,  32'hC0000040, 32'd7,  32'd1, 32'h0000000B, 32'hC0000040, 32'h108},
    '{32'd5,  32'hC0000003, 32'd8,  32'd0, 32'h08000005, 32'h00000005, 32'h100},
    '{32'd1,  32'hC0000040, 32'd1,  32'd0, 32'h00000003, 32'hC0000040, 32'h108}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic crc_wide = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0, s_ready;
  logic [7:0] s_data = '0;
  logic mem_req, mem_we, mem_rdy = 1'b0, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic [31:0] mem [0:4095];

  int checks = 0, fails = 0, cycles = 0;
  int irq_cnt = 0, txn_cnt = 0, wr_cnt = 0, hold_err = 0;
  int wait_cnt = 0, dly = 0;
  logic hold_v = 1'b0, hold_we = 1'b0, saw_b = 1'b0;
  logic [31:0] hold_a = '0, last_wa = '0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  rx_ring_dma u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .crc_wide_i(crc_wide),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_last_i(s_last), .s_ready_o(s_ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_be_o(mem_be), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_rdy), .irq_o(irq)
  );

  assign mem_rdata = mem[mem_addr[13:2]];

  // memory responder: latency rotates 1..3 cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rdy = 1'b0;
    end else if (mem_rdy) begin
      mem_rdy = 1'b0;
    end else if (mem_req) begin
      if (hold_v && (mem_addr != hold_a || mem_we != hold_we)) hold_err++;
      hold_v = 1'b1; hold_a = mem_addr; hold_we = mem_we;
      if (wait_cnt >= dly) begin
        if (mem_we) begin
          for (int l = 0; l < 4; l++)
            if (mem_be[l]) mem[mem_addr[13:2]][8*l +: 8] = mem_wdata[8*l +: 8];
          wr_cnt++;
          last_wa = mem_addr;
          if (mem_addr == DB) saw_b = 1'b1;
        end
        txn_cnt++;
        mem_rdy = 1'b1;
        wait_cnt = 0;
        dly = (dly + 1) % 3;
        hold_v = 1'b0;
      end else begin
        wait_cnt++;
      end
    end
    if (irq) irq_cnt++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_byte(input logic [31:0] a);
    return mem[a[13:2]][8*a[1:0] +: 8];
  endfunction

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send_pkt(input int n, input logic [7:0] seed);
    for (int k = 0; k < n; k++) begin
      s_valid = 1'b1; s_data = seed + 8'(k); s_last = (k == n - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic wait_irq(input int i0);
    for (int t = 0; t < 400 && irq_cnt == i0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic prep(input logic [31:0] wa, input logic [31:0] wb);
    for (int i = 0; i < 4096; i++) mem[i] = 32'hEEEEEEEE;
    mem[DA[13:2]] = wa; mem[DA[13:2] + 1] = BA;
    mem[DB[13:2]] = wb; mem[DB[13:2] + 1] = BB;
    saw_b = 1'b0; last_wa = '0;
    reg_wr(4'h4, DA);
    reg_wr(4'h8, DA);
  endtask

  function automatic int buf_errs(input logic [31:0] base, input int n, input int span,
                                  input logic [7:0] first);
    int e = 0;
    for (int k = 0; k < span; k++)
      if (rd_byte(base + 32'(k)) !== ((k < n) ? 8'(first + 8'(k)) : 8'hEE)) e++;
    return e;
  endfunction

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected<=150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
        $finish;
      end
    end
  end

  initial begin : main
    logic [31:0] rd;
    int i0, t0, w0, na, nb, plen, lena, lenb;
    logic [7:0] seed;
    repeat (3) @(negedge clk);
    // reset state
    reg_rd(4'h4, rd); chk("R11 reset start", rd, 0);
    reg_rd(4'h8, rd); chk("R11 reset cur", rd, 0);
    chk("R9 reset irq", 32'(irq), 0);
    chk("R12 reset req", 32'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 idle ready", 32'(s_ready), 0);

    // register access
    reg_wr(4'h4, 32'h0000A5A0);
    reg_wr(4'h8, 32'h0000B5B8);
    reg_rd(4'h4, rd); chk("R11 start rw", rd, 32'h0000A5A0);
    reg_rd(4'h8, rd); chk("R11 cur rw", rd, 32'h0000B5B8);
    reg_rd(4'hC, rd); chk("R11 other zero", rd, 0);

    // vector table walk
    for (int v = 0; v < 6; v++) begin
      lena = int'(VEC[v][0]); lenb = int'(VEC[v][1][12:0]); plen = int'(VEC[v][2]);
      seed = 8'(16 * v + 1);
      crc_wide = VEC[v][3][0];
      prep(32'h80000000 | VEC[v][0], VEC[v][1]);
      i0 = irq_cnt;
      send_pkt(plen, seed);
      wait_irq(i0);
      na = (plen < lena) ? plen : lena;
      nb = VEC[v][1][31] ? (((plen - na) < lenb) ? plen - na : lenb) : 0;
      chk($sformatf("R6_R7 first status v%0d", v), mem[DA[13:2]], VEC[v][4]);
      chk($sformatf("R7_R8 second status v%0d", v), mem[DB[13:2]], VEC[v][5]);
      reg_rd(4'h8, rd);
      chk($sformatf("R5 cur v%0d", v), rd, VEC[v][6]);
      chk($sformatf("R1 bufA bytes v%0d", v), 32'(buf_errs(BA, na, lena + 4, seed)), 0);
      chk($sformatf("R4 bufB bytes v%0d", v),
          32'(buf_errs(BB, nb, lenb + 4, seed + 8'(na))), 0);
      chk($sformatf("R9 last write v%0d", v), last_wa, DA);
      chk($sformatf("R9 irq v%0d", v), 32'(irq_cnt - i0), 1);
      chk($sformatf("R9 chained write v%0d", v), 32'(saw_b),
          32'(VEC[v][5] != VEC[v][1]));
    end

    // ring start zero drops
    prep(32'h80000040, 32'hC0000040);
    reg_wr(4'h4, 32'h0);
    i0 = irq_cnt; t0 = txn_cnt;
    send_pkt(5, 8'h33);
    repeat (20) @(negedge clk);
    chk("R2 no memory access", 32'(txn_cnt - t0), 0);
    chk("R2 no irq", 32'(irq_cnt - i0), 0);

    // unowned current descriptor drops
    prep(32'h40000040, 32'hC0000040);
    i0 = irq_cnt; w0 = wr_cnt;
    send_pkt(6, 8'h44);
    repeat (20) @(negedge clk);
    chk("R3 no writes", 32'(wr_cnt - w0), 0);
    chk("R3 no irq", 32'(irq_cnt - i0), 0);
    reg_rd(4'h8, rd); chk("R3 cur kept", rd, DA);
    chk("R3 desc kept", mem[DA[13:2]], 32'h40000040);

    // truncation at 8192 bytes, then a following packet
    crc_wide = 1'b1;
    prep(32'h80001FFF, 32'hC0001FFF);
    i0 = irq_cnt;
    send_pkt(8200, 8'h05);
    wait_irq(i0);
    chk("R10 first status", mem[DA[13:2]], 32'h08001FFF);
    chk("R10 second status", mem[DB[13:2]], 32'h00000005);
    chk("R10 last byte", 32'(rd_byte(BB)), 32'(8'(8'h05 + 8'(8191))));
    chk("R10 next byte untouched", 32'(rd_byte(BB + 1)), 32'hEE);
    reg_rd(4'h8, rd); chk("R10 cur", rd, DA);
    crc_wide = 1'b0;
    mem[DA[13:2]] = 32'h80000040;
    i0 = irq_cnt;
    send_pkt(4, 8'h70);
    wait_irq(i0);
    chk("R10 after drain status", mem[DA[13:2]], 32'h00000006);
    chk("R10 after drain irq", 32'(irq_cnt - i0), 1);

    chk("R12 request held", 32'(hold_err), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule